// File: doc/BRIEF.md
# Secure Exception Routing Controller

This block holds a small secure configuration word and derives three things from it: the effective security state of the core, the mode that each asynchronous exception class (IRQ, FIQ, external abort) should enter, and whether a requested update of the status register's abort mask (A) or fast-interrupt mask (F) may proceed. Each exception class has its own routing bit. When that bit is set, the class is taken to the monitor mode instead of its usual handler mode.

The core presents its current mode every cycle. It can also raise requests to change the A and F mask bits. The block answers combinationally with gated write enables. Privileged code running in the Secure state may rewrite the configuration word. The new value takes effect from the cycle after the write. The block also flags the two pairings of the FIQ-routing bit and the F-mask permission bit that software should avoid.

Top module: `sec_route_ctrl`

## Requirements
- R1: After reset, every configuration bit is 0 and the read-back word is 0. IRQ, FIQ and abort targets are therefore IRQ (code 2), FIQ (code 1) and abort (code 4).
- R2: A configuration write in a privileged mode while the effective state is Secure is visible on the read-back word from the next cycle. Bits [5:0] take the written value, and bit 6 and every bit above it read 0. Bit 0 is world select (1 = Non-secure), bit 1 is IRQ routing, bit 2 is FIQ routing, bit 3 is abort routing, bit 4 is F-mask permission and bit 5 is A-mask permission.
- R3: A configuration write is ignored, and the read-back word is unchanged, when the effective state is Non-secure or the mode is user (code 0).
- R4: The secure output is 1 when bit 0 is 0 or the mode is monitor (code 7). The bank-select output always equals bit 0, even in monitor mode.
- R5: The IRQ target mode is monitor (7) when bit 1 is 1, else IRQ (2).
- R6: The FIQ target mode is monitor (7) when bit 2 is 1, else FIQ (1).
- R7: The external-abort target mode is monitor (7) when bit 3 is 1, else abort (4).
- R8: The A-mask write enable is 1 only when an A update is requested, the mode is not user (0), and either the state is Secure or bit 5 is 1.
- R9: The F-mask write enable is 1 only when an F update is requested, the mode is not user (0), and either the state is Secure or bit 4 is 1.
- R10: The warning output is 1 exactly when bit 4 equals bit 2.
- R11: Routing, mask gating and warning use the configuration held at the start of the cycle. A write changes them from the following cycle.

Mode codes: 0 user, 1 FIQ, 2 IRQ, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write request |
| cfg_wdata | input | REG_W | Configuration write data |
| cfg_rdata | output | REG_W | Configuration read-back word |
| cur_mode | input | 3 | Current processor mode code |
| a_upd_req | input | 1 | Request to change the A mask bit |
| f_upd_req | input | 1 | Request to change the F mask bit |
| secure_o | output | 1 | Effective Secure state |
| bank_ns_o | output | 1 | Banked-register select (follows bit 0) |
| irq_mode_o | output | 3 | Target mode for IRQ |
| fiq_mode_o | output | 3 | Target mode for FIQ |
| abt_mode_o | output | 3 | Target mode for external abort |
| a_upd_en | output | 1 | Gated A-mask write enable |
| f_upd_en | output | 1 | Gated F-mask write enable |
| route_warn_o | output | 1 | Hazardous FIQ/F-permission pairing |

## Verification
A configuration write and a mask-bit update request can arrive in the same cycle, and the write may itself flip the security state. The bench provokes this from supervisor mode with bit 0 clear. In one cycle it writes bit 0 = 1 with bit 5 = 0 and raises an A update request. The enable must be granted in that cycle, because the state is still Secure. In the next cycle the enable must be refused and the secure output must be low. Around this case, every combination of bits [5:0], all eight modes and both request lines is swept against expected values computed arithmetically.

// File: rtl/src_pkg.sv
// Package: shared mode codes and configuration bit positions.
// Assumes the core presents its mode as the 3-bit code defined here.
package src_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 3'd0,
        MODE_FIQ = 3'd1,
        MODE_IRQ = 3'd2,
        MODE_SVC = 3'd3,
        MODE_ABT = 3'd4,
        MODE_UND = 3'd5,
        MODE_SYS = 3'd6,
        MODE_MON = 3'd7
    } mode_t;

    // Bit positions inside the configuration word.
    localparam int B_NS   = 0;
    localparam int B_IRQ  = 1;
    localparam int B_FIQ  = 2;
    localparam int B_EA   = 3;
    localparam int B_FW   = 4;
    localparam int B_AW   = 5;
    localparam int CFG_LIVE = 6;

    // Exception classes routed by the controller.
    localparam int N_CLASS = 3;
    // Mask bits gated by the controller (index 0 = A, 1 = F).
    localparam int N_MASK  = 2;
endpackage

// File: rtl/src_cfg_reg.sv
// Module: configuration storage.
// Holds the live configuration bits. The read-back word zero-fills every
// bit above them. Assumes the write qualifier is already decided upstream.
module src_cfg_reg #(
    parameter int REG_W = 32,
    parameter int LIVE  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [LIVE-1:0]  cfg_q,
    output logic [REG_W-1:0] rd_data
);
    localparam int PAD_W = REG_W - LIVE;

    logic unused_hi;

    // Fold away the write bits that have no storage.
    assign unused_hi = ^wr_data[REG_W-1:LIVE];

    // Capture qualified writes; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data[LIVE-1:0];
        end
    end

    // Present the stored bits with zero padding above them.
    assign rd_data = {{PAD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/src_route.sv
// Module: per-class exception target selection.
// Each class goes to the monitor code when its routing bit is set, and to
// its home mode otherwise. Purely combinational.
module src_route #(
    parameter int N  = 3,
    parameter int MW = 3,
    parameter logic [MW-1:0] MON_CODE = '1
) (
    input  logic [N-1:0]    route_bits,
    input  logic [N*MW-1:0] home_modes,
    output logic [N*MW-1:0] tgt_modes
);
    // One selector per exception class.
    for (genvar g = 0; g < N; g++) begin : g_class
        assign tgt_modes[g*MW +: MW] = route_bits[g] ? MON_CODE
                                                     : home_modes[g*MW +: MW];
    end
endmodule

// File: rtl/src_mask_gate.sv
// Module: status-register mask-bit write gating.
// A request passes only from a privileged mode, and only when the state is
// Secure or the per-bit permission is set. Purely combinational.
module src_mask_gate #(
    parameter int N = 2
) (
    input  logic         secure,
    input  logic         priv,
    input  logic [N-1:0] req,
    input  logic [N-1:0] perm,
    output logic [N-1:0] en
);
    // One gate per mask bit.
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign en[g] = req[g] & priv & (secure | perm[g]);
    end
endmodule

// File: rtl/sec_route_ctrl.sv
// Module: secure exception routing controller (top).
// Derives the effective security state, the per-class exception targets,
// the gated mask-bit write enables and a configuration hazard flag from the
// stored configuration and the current mode. Assumes cur_mode holds a code
// from src_pkg. Configuration writes are accepted only from privileged
// Secure code.
module sec_route_ctrl
    import src_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [2:0]       cur_mode,
    input  logic             a_upd_req,
    input  logic             f_upd_req,
    output logic             secure_o,
    output logic             bank_ns_o,
    output logic [2:0]       irq_mode_o,
    output logic [2:0]       fiq_mode_o,
    output logic [2:0]       abt_mode_o,
    output logic             a_upd_en,
    output logic             f_upd_en,
    output logic             route_warn_o
);
    localparam int RT_W = N_CLASS * MODE_W;

    logic [CFG_LIVE-1:0] cfg_q;
    logic                in_mon;
    logic                priv;
    logic                wr_ok;
    logic [RT_W-1:0]     home_modes;
    logic [RT_W-1:0]     tgt_modes;
    logic [N_MASK-1:0]   mask_req;
    logic [N_MASK-1:0]   mask_perm;
    logic [N_MASK-1:0]   mask_en;

    // Mode decode: monitor forces Secure; user mode is unprivileged.
    always_comb begin
        in_mon = (cur_mode == MODE_MON);
        priv   = (cur_mode != MODE_USR);
    end

    // Effective state and bank select.
    assign secure_o  = ~cfg_q[B_NS] | in_mon;
    assign bank_ns_o = cfg_q[B_NS];

    // Writes pass only from privileged Secure code.
    assign wr_ok = cfg_we & priv & secure_o;

    src_cfg_reg #(
        .REG_W (REG_W),
        .LIVE  (CFG_LIVE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .rd_data (cfg_rdata)
    );

    // Home modes, class order: IRQ, FIQ, abort.
    assign home_modes = {MODE_ABT, MODE_FIQ, MODE_IRQ};

    src_route #(
        .N        (N_CLASS),
        .MW       (MODE_W),
        .MON_CODE (MODE_MON)
    ) u_route (
        .route_bits (cfg_q[B_EA:B_IRQ]),
        .home_modes (home_modes),
        .tgt_modes  (tgt_modes)
    );

    assign irq_mode_o = tgt_modes[0*MODE_W +: MODE_W];
    assign fiq_mode_o = tgt_modes[1*MODE_W +: MODE_W];
    assign abt_mode_o = tgt_modes[2*MODE_W +: MODE_W];

    // Mask gating: index 0 is A (permission AW), index 1 is F (permission FW).
    assign mask_req  = {f_upd_req, a_upd_req};
    assign mask_perm = {cfg_q[B_FW], cfg_q[B_AW]};

    src_mask_gate #(
        .N (N_MASK)
    ) u_gate (
        .secure (secure_o),
        .priv   (priv),
        .req    (mask_req),
        .perm   (mask_perm),
        .en     (mask_en)
    );

    assign a_upd_en = mask_en[0];
    assign f_upd_en = mask_en[1];

    // Flag both unsafe pairings of FIQ routing and F permission.
    assign route_warn_o = ~(cfg_q[B_FW] ^ cfg_q[B_FIQ]);
endmodule

// File: rtl/sec_route_ctrl_chk.sv
// Checker: port-level properties of sec_route_ctrl, attached by bind.
module sec_route_ctrl_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic [2:0]       cur_mode,
    input logic             a_upd_req,
    input logic             f_upd_req,
    input logic             secure_o,
    input logic             bank_ns_o,
    input logic [2:0]       irq_mode_o,
    input logic [2:0]       fiq_mode_o,
    input logic [2:0]       abt_mode_o,
    input logic             a_upd_en,
    input logic             f_upd_en,
    input logic             route_warn_o
);
    // R1: the first cycle out of reset shows a cleared word.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == '0));

    // R2: an accepted write appears next cycle, masked to the live bits.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && secure_o && cur_mode != 3'd0) |=>
        (cfg_rdata == {{(REG_W-6){1'b0}}, $past(cfg_wdata[5:0])}));

    // R2: the bits above the live field stay zero.
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:6] == '0);

    // R3: a refused write leaves the word untouched.
    p_refused_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (!secure_o || cur_mode == 3'd0)) |=> $stable(cfg_rdata));

    // R4: monitor mode is always Secure, and the bank select tracks bit 0.
    p_monitor_secure_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd7) |-> (secure_o && bank_ns_o == cfg_rdata[0]));

    // R5: IRQ target against the read-back routing bit.
    p_irq_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mode_o == (cfg_rdata[1] ? 3'd7 : 3'd2));

    // R6: FIQ target against the read-back routing bit.
    p_fiq_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_mode_o == (cfg_rdata[2] ? 3'd7 : 3'd1));

    // R7: abort target against the read-back routing bit.
    p_abt_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abt_mode_o == (cfg_rdata[3] ? 3'd7 : 3'd4));

    // R8: an A enable needs a request, privilege and Secure state or AW.
    p_a_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_upd_en |-> (a_upd_req && cur_mode != 3'd0 && (secure_o || cfg_rdata[5])));

    // R9: an F enable needs a request, privilege and Secure state or FW.
    p_f_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        f_upd_en |-> (f_upd_req && cur_mode != 3'd0 && (secure_o || cfg_rdata[4])));

    // R10: warning flags equal FIQ-routing and F-permission bits.
    p_warn_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        route_warn_o == (cfg_rdata[4] == cfg_rdata[2]));
endmodule

bind sec_route_ctrl sec_route_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sec_route_ctrl_tb.sv
module sec_route_ctrl_tb;
    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [REG_W-1:0] cfg_wdata = '0;
    logic [REG_W-1:0] cfg_rdata;
    logic [2:0]       cur_mode = 3'd7;
    logic             a_upd_req = 1'b0;
    logic             f_upd_req = 1'b0;
    logic             secure_o, bank_ns_o;
    logic [2:0]       irq_mode_o, fiq_mode_o, abt_mode_o;
    logic             a_upd_en, f_upd_en, route_warn_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sec_route_ctrl #(.REG_W(REG_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a write for one edge from the given mode, then release it.
    task automatic do_write(input logic [2:0] m, input logic [REG_W-1:0] d);
        @(negedge clk);
        cur_mode  = m;
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rdata", cfg_rdata, 32'h0);
        chk("R1 irq", {29'd0, irq_mode_o}, 32'd2);
        chk("R1 fiq", {29'd0, fiq_mode_o}, 32'd1);
        chk("R1 abt", {29'd0, abt_mode_o}, 32'd4);

        // Exhaustive sweep: configuration x mode x requests.
        for (int v = 0; v < 64; v++) begin
            do_write(3'd7, 32'hFFFF_FFC0 | 32'(v));
            #1;
            chk("R2 readback", cfg_rdata, 32'(v));
            for (int m = 0; m < 8; m++) begin
                for (int rq = 0; rq < 4; rq++) begin
                    logic sec, ae, fe;
                    cur_mode  = 3'(m);
                    a_upd_req = rq[0];
                    f_upd_req = rq[1];
                    #1;
                    sec = (v[0] == 1'b0) || (m == 7);
                    ae  = rq[0] && (m != 0) && (sec || v[5]);
                    fe  = rq[1] && (m != 0) && (sec || v[4]);
                    chk("R4 secure", {31'd0, secure_o}, {31'd0, sec});
                    chk("R4 bank", {31'd0, bank_ns_o}, {31'd0, v[0]});
                    chk("R5 irq", {29'd0, irq_mode_o}, v[1] ? 32'd7 : 32'd2);
                    chk("R6 fiq", {29'd0, fiq_mode_o}, v[2] ? 32'd7 : 32'd1);
                    chk("R7 abt", {29'd0, abt_mode_o}, v[3] ? 32'd7 : 32'd4);
                    chk("R8 a_en", {31'd0, a_upd_en}, {31'd0, ae});
                    chk("R9 f_en", {31'd0, f_upd_en}, {31'd0, fe});
                    chk("R10 warn", {31'd0, route_warn_o}, {31'd0, v[4] == v[2]});
                end
            end
        end
        a_upd_req = 1'b0;
        f_upd_req = 1'b0;

        // R2: write from supervisor while Secure is accepted.
        do_write(3'd7, 32'h0);
        do_write(3'd3, 32'h0000_0016);
        #1;
        chk("R2 svc write", cfg_rdata, 32'h16);

        // R3: write from user mode ignored.
        do_write(3'd0, 32'h0000_0009);
        #1;
        chk("R3 user write", cfg_rdata, 32'h16);
        chk("R5 after user write", {29'd0, irq_mode_o}, 32'd7);

        // R3: write while Non-secure (bit 0 set, supervisor) ignored.
        do_write(3'd7, 32'h0000_0001);
        do_write(3'd3, 32'h0000_003E);
        #1;
        chk("R3 nonsecure write", cfg_rdata, 32'h1);
        chk("R7 after nonsecure write", {29'd0, abt_mode_o}, 32'd4);

        // R11: same-cycle write that flips the state plus an A request.
        do_write(3'd7, 32'h0);
        @(negedge clk);
        cur_mode  = 3'd3;
        cfg_we    = 1'b1;
        cfg_wdata = 32'h0000_0001;
        a_upd_req = 1'b1;
        #1;
        chk("R11 a_en same cycle", {31'd0, a_upd_en}, 32'd1);
        chk("R11 secure same cycle", {31'd0, secure_o}, 32'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R11 secure next cycle", {31'd0, secure_o}, 32'd0);
        chk("R11 a_en next cycle", {31'd0, a_upd_en}, 32'd0);
        a_upd_req = 1'b0;

        // R1: reset clears a loaded configuration.
        do_write(3'd7, 32'h0000_003F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset again", cfg_rdata, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule